// File: doc/BRIEF.md
# Programmable Asynchronous Display Bus Waveform Generator

This block drives a parallel display panel over an asynchronous microcontroller-style bus. Each request names one panel access: a command or a data word, and a read or a write. The block then opens a window whose length is a count of clock cycles. The window length is programmed separately for command writes, data writes and reads. Inside the window, four generic level generators shape the waveforms. Each generator has a programmable rise point and a programmable fall point. A per-access routing then picks which generator feeds the chip select and which feeds the strobe.

One mode input chooses the pin convention. The 8080 convention uses separate write and read strobes. The 6800 convention uses a read/write direction line plus an enable. The register-select line tells command from data. The data bus appears as an output word, an output enable and an input word, which a pad cell joins into one bidirectional bus.

No setup or hold time is built in. All timing margin comes from the programmed counts. An idle gap between accesses comes from making the window longer than the last generator edge.

Top module: `adbus_wavegen`

## Requirements
- R1: When no access is in progress, and also during reset, the pins rest as follows: `ready`=1, `cs_n`=1, `rs`=1 and `bus_oe`=0. In 8080 mode (`mode_6800`=0), `wr_n`=1 and `rd_n`=1. In 6800 mode, `wr_n` (direction) = 1 and `rd_n` (enable) = 0.
- R2: A request is accepted at a rising edge where `req_valid` and `ready` are both 1. `ready` is then low for S cycles, and S is chosen as follows:
  - `size_rd` for any read;
  - `size_cmd_wr` for a command write;
  - `size_dat_wr` for a data write;
  - a size of 0 acts as 1.
  
  In the first cycle that `ready` is high again, `done` is 1 for exactly that one cycle.
- R3: Window cycle k counts from 0, the first cycle after acceptance, up to S-1. Generator g is active in cycle k when UP_g <= k < DN_g. If UP_g >= DN_g, the generator stays inactive for the whole window. UP_g is held in `gen_up[g*CW +: CW]` and DN_g in `gen_dn[g*CW +: CW]`.
- R4: The chip-select generator index and the strobe generator index are 2-bit fields. Writes use `map_wr_cs` and `map_wr_stb`; reads use `map_rd_cs` and `map_rd_stb`. During a window, `cs_n` is the inverse of the chip-select generator's level.
- R5: In 8080 mode, a write drives `wr_n` as the inverse of the strobe generator and holds `rd_n`=1. A read drives `rd_n` as the inverse of the strobe generator and holds `wr_n`=1.
- R6: In 6800 mode, `wr_n` carries the direction for the whole window: 1 for a read, 0 for a write. `rd_n` carries the active-high enable, which equals the strobe generator's level.
- R7: During a window, `rs` is 0 for a command access and 1 for a data access.
- R8: During every cycle of a write window, `bus_oe`=1 and `bus_out` equals the accepted `req_wdata`. During a read window, `bus_oe`=0.
- R9: For a read, `bus_in` is captured at the end of window cycle k = DN of the strobe generator. This happens only when that generator's UP < DN and DN < S. In the next cycle, `rd_valid`=1 for one cycle and `rd_data` holds the captured word. Writes, and reads with no such cycle, give no `rd_valid`.
- R10: All of these are sampled at acceptance:
  - the generator counts;
  - the routing fields;
  - the window sizes;
  - the access kind and the write data.
  
  Changing those inputs during a window has no effect on that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_6800 | input | 1 | 0: 8080 pin convention, 1: 6800 pin convention |
| gen_up | input | NGEN*CW | Rise count per generator |
| gen_dn | input | NGEN*CW | Fall count per generator |
| size_cmd_wr | input | CW | Window length, command write |
| size_dat_wr | input | CW | Window length, data write |
| size_rd | input | CW | Window length, reads |
| map_wr_cs | input | 2 | Chip-select generator for writes |
| map_wr_stb | input | 2 | Strobe generator for writes |
| map_rd_cs | input | 2 | Chip-select generator for reads |
| map_rd_stb | input | 2 | Strobe generator for reads |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1: read access, 0: write access |
| req_cmd | input | 1 | 1: command access, 0: data access |
| req_wdata | input | DW | Write word |
| ready | output | 1 | Block idle, request can be taken |
| done | output | 1 | One-cycle pulse when a window ends |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe (8080) or read/write direction (6800) |
| rd_n | output | 1 | Read strobe, active low (8080) or enable, active high (6800) |
| rs | output | 1 | Register select: 0 command, 1 data |
| bus_out | output | DW | Data driven toward the panel |
| bus_oe | output | 1 | Output enable for the data pads |
| bus_in | input | DW | Data returned from the pads |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` valid |

## Verification
The assertions check, on every cycle, properties that hold regardless of the programmed counts:
- the idle pin levels;
- that `ready` drops after acceptance;
- that the two 8080 strobes are never low together;
- that the bus is driven only inside a window;
- that the read pulse is single and only follows a window.

The exact cycle of each generator edge needs a cycle-by-cycle reference model fed with changing counts, routings, sizes and modes. So do the capture point for reads, the per-kind window lengths, and the immunity of a running window to configuration changes. Only the bench's scenarios can show these.

// File: rtl/adbus_wavegen.sv
module adbus_wavegen #(
  parameter int CW   = 8,
  parameter int DW   = 16,
  parameter int NGEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_6800,
  input  logic [NGEN*CW-1:0]   gen_up,
  input  logic [NGEN*CW-1:0]   gen_dn,
  input  logic [CW-1:0]        size_cmd_wr,
  input  logic [CW-1:0]        size_dat_wr,
  input  logic [CW-1:0]        size_rd,
  input  logic [1:0]           map_wr_cs,
  input  logic [1:0]           map_wr_stb,
  input  logic [1:0]           map_rd_cs,
  input  logic [1:0]           map_rd_stb,
  input  logic                 req_valid,
  input  logic                 req_read,
  input  logic                 req_cmd,
  input  logic [DW-1:0]        req_wdata,
  output logic                 ready,
  output logic                 done,
  output logic                 cs_n,
  output logic                 wr_n,
  output logic                 rd_n,
  output logic                 rs,
  output logic [DW-1:0]        bus_out,
  output logic                 bus_oe,
  input  logic [DW-1:0]        bus_in,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_valid
);
  localparam int SW = 2;

  logic               busy;
  logic [CW-1:0]      k;
  logic [CW-1:0]      len_q;
  logic [NGEN*CW-1:0] up_q, dn_q;
  logic [SW-1:0]      sel_cs, sel_stb;
  logic               rd_q, cmd_q;
  logic [DW-1:0]      wd_q;
  logic               done_q, rv_q;
  logic [DW-1:0]      rdat_q;

  logic [CW-1:0]      up_a [NGEN];
  logic [CW-1:0]      dn_a [NGEN];
  logic [NGEN-1:0]    lvl;

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    assign up_a[g] = up_q[g*CW +: CW];
    assign dn_a[g] = dn_q[g*CW +: CW];
    assign lvl[g]  = busy && (up_a[g] < dn_a[g]) && (k >= up_a[g]) && (k < dn_a[g]);
  end

  logic          cs_lvl, stb_lvl, last, grab, take;
  logic [CW:0]   k_nx;

  assign cs_lvl  = lvl[sel_cs];
  assign stb_lvl = lvl[sel_stb];
  assign k_nx    = {1'b0, k} + {{CW{1'b0}}, 1'b1};
  assign last    = k_nx >= {1'b0, len_q};
  assign grab    = busy && rd_q && (up_a[sel_stb] < dn_a[sel_stb]) && (k == dn_a[sel_stb]);
  assign take    = !busy && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      k       <= '0;
      len_q   <= '0;
      up_q    <= '0;
      dn_q    <= '0;
      sel_cs  <= '0;
      sel_stb <= '0;
      rd_q    <= 1'b0;
      cmd_q   <= 1'b0;
      wd_q    <= '0;
      done_q  <= 1'b0;
      rv_q    <= 1'b0;
      rdat_q  <= '0;
    end else begin
      done_q <= busy && last;
      rv_q   <= grab;
      if (grab) rdat_q <= bus_in;
      if (busy) begin
        if (last) busy <= 1'b0;
        else      k    <= k_nx[CW-1:0];
      end else if (take) begin
        busy    <= 1'b1;
        k       <= '0;
        up_q    <= gen_up;
        dn_q    <= gen_dn;
        rd_q    <= req_read;
        cmd_q   <= req_cmd;
        wd_q    <= req_wdata;
        len_q   <= req_read ? size_rd : (req_cmd ? size_cmd_wr : size_dat_wr);
        sel_cs  <= req_read ? map_rd_cs  : map_wr_cs;
        sel_stb <= req_read ? map_rd_stb : map_wr_stb;
      end
    end
  end

  assign ready    = !busy;
  assign done     = done_q;
  assign cs_n     = !cs_lvl;
  assign rs       = !(busy && cmd_q);
  assign wr_n     = mode_6800 ? (!busy || rd_q) : !(busy && !rd_q && stb_lvl);
  assign rd_n     = mode_6800 ? stb_lvl         : !(busy && rd_q && stb_lvl);
  assign bus_oe   = busy && !rd_q;
  assign bus_out  = wd_q;
  assign rd_data  = rdat_q;
  assign rd_valid = rv_q;
endmodule

// File: rtl/adbus_wavegen_chk.sv
module adbus_wavegen_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_6800,
  input logic req_valid,
  input logic ready,
  input logic done,
  input logic cs_n,
  input logic wr_n,
  input logic rd_n,
  input logic rs,
  input logic bus_oe,
  input logic rd_valid
);
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs_n && rs && !bus_oe));
  assert_idle_8080_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !mode_6800) |-> (wr_n && rd_n));
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);
  assert_done_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && $past(!ready)));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_6800 |-> (wr_n || rd_n));
  assert_drive_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !ready);
  assert_rv_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!bus_oe && $past(!ready)));
  assert_rv_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind adbus_wavegen adbus_wavegen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_6800(mode_6800), .req_valid(req_valid),
  .ready(ready), .done(done), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
  .rs(rs), .bus_oe(bus_oe), .rd_valid(rd_valid)
);

// File: tb/adbus_wavegen_tb.sv
module adbus_wavegen_tb;
  localparam int PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 16;
  localparam int NG = 4;
  localparam int NCYC = 30000;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic rst_n, mode_6800, req_valid, req_read, req_cmd;
  logic [NG*CW-1:0] gen_up, gen_dn;
  logic [CW-1:0] size_cmd_wr, size_dat_wr, size_rd;
  logic [1:0] map_wr_cs, map_wr_stb, map_rd_cs, map_rd_stb;
  logic [DW-1:0] req_wdata, bus_in, bus_out, rd_data;
  logic ready, done, cs_n, wr_n, rd_n, rs, bus_oe, rd_valid;

  adbus_wavegen #(.CW(CW), .DW(DW), .NGEN(NG)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_6800(mode_6800),
    .gen_up(gen_up), .gen_dn(gen_dn),
    .size_cmd_wr(size_cmd_wr), .size_dat_wr(size_dat_wr), .size_rd(size_rd),
    .map_wr_cs(map_wr_cs), .map_wr_stb(map_wr_stb),
    .map_rd_cs(map_rd_cs), .map_rd_stb(map_rd_stb),
    .req_valid(req_valid), .req_read(req_read), .req_cmd(req_cmd),
    .req_wdata(req_wdata), .ready(ready), .done(done),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .rs(rs),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int total = 0;
  int fails = 0;

  // behavioural reference state
  bit m_busy = 0, m_rd = 0, m_cmd = 0, m_done = 0, m_rv = 0;
  int m_k = 0, m_len = 0, m_mcs = 0, m_mstb = 0, m_wd = 0, m_rdat = 0;
  int m_up[NG], m_dn[NG];
  int n_rv = 0, n_done = 0, n_acc6800 = 0, n_reads = 0;

  always @(posedge clk) begin : model
    bit nd, nv;
    nd = 0; nv = 0;
    if (!rst_n) begin
      m_busy = 0; m_k = 0;
    end else if (m_busy) begin
      if (m_rd && m_up[m_mstb] < m_dn[m_mstb] && m_k == m_dn[m_mstb]) begin
        nv = 1; m_rdat = int'(bus_in); n_rv++;
      end
      if (m_k + 1 >= m_len) begin m_busy = 0; nd = 1; n_done++; end
      else m_k++;
    end else if (req_valid) begin
      m_busy = 1; m_k = 0;
      m_rd = req_read; m_cmd = req_cmd; m_wd = int'(req_wdata);
      m_len = req_read ? int'(size_rd) : (req_cmd ? int'(size_cmd_wr) : int'(size_dat_wr));
      m_mcs  = req_read ? int'(map_rd_cs)  : int'(map_wr_cs);
      m_mstb = req_read ? int'(map_rd_stb) : int'(map_wr_stb);
      for (int g = 0; g < NG; g++) begin
        m_up[g] = int'(gen_up[g*CW +: CW]);
        m_dn[g] = int'(gen_dn[g*CW +: CW]);
      end
      if (mode_6800) n_acc6800++;
      if (req_read) n_reads++;
    end
    m_done = nd; m_rv = nv;
  end

  function automatic bit act(int g);
    return m_busy && m_up[g] < m_dn[g] && m_k >= m_up[g] && m_k < m_dn[g];
  endfunction

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic compare();
    bit e_cs, e_wr, e_rd, e_rs, e_oe, stb;
    stb  = act(m_mstb);
    e_cs = !act(m_mcs);
    e_rs = !(m_busy && m_cmd);
    e_oe = m_busy && !m_rd;
    if (mode_6800) begin
      e_wr = !m_busy || m_rd;
      e_rd = stb;
    end else begin
      e_wr = !(m_busy && !m_rd && stb);
      e_rd = !(m_busy && m_rd && stb);
    end
    chk(ready === !m_busy, "R2 ready", int'(ready), int'(!m_busy));
    chk(done === m_done, "R2 done", int'(done), int'(m_done));
    chk(cs_n === e_cs, m_busy ? "R4 cs_n" : "R1 cs_n", int'(cs_n), int'(e_cs));
    chk(rs === e_rs, m_busy ? "R7 rs" : "R1 rs", int'(rs), int'(e_rs));
    chk(wr_n === e_wr, mode_6800 ? "R6 wr_n" : "R5 wr_n", int'(wr_n), int'(e_wr));
    chk(rd_n === e_rd, mode_6800 ? "R6 rd_n" : "R3 R5 rd_n", int'(rd_n), int'(e_rd));
    chk(bus_oe === e_oe, "R8 bus_oe", int'(bus_oe), int'(e_oe));
    if (e_oe) chk(int'(bus_out) == m_wd, "R8 R10 bus_out", int'(bus_out), m_wd);
    chk(rd_valid === m_rv, "R9 rd_valid", int'(rd_valid), int'(m_rv));
    if (m_rv) chk(int'(rd_data) == m_rdat, "R9 rd_data", int'(rd_data), m_rdat);
  endtask

  task automatic new_config();
    for (int g = 0; g < NG; g++) begin
      gen_up[g*CW +: CW] = CW'($urandom % 8);
      gen_dn[g*CW +: CW] = CW'($urandom % 16);
    end
    size_cmd_wr = CW'($urandom % 14);
    size_dat_wr = CW'($urandom % 14);
    size_rd     = CW'($urandom % 18);
    map_wr_cs  = 2'($urandom); map_wr_stb = 2'($urandom);
    map_rd_cs  = 2'($urandom); map_rd_stb = 2'($urandom);
  endtask

  task automatic drive();
    req_valid = ($urandom % 10) < 7;
    req_read  = 1'($urandom);
    req_cmd   = 1'($urandom);
    req_wdata = DW'($urandom);
    bus_in    = DW'($urandom);
    if ($urandom % 8 == 0) new_config();  // R10: changes land mid-window too
    if ($urandom % 300 == 0) mode_6800 = ~mode_6800;
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 0; mode_6800 = 0; req_valid = 0; req_read = 0; req_cmd = 0;
    req_wdata = '0; bus_in = '0;
    // directed start: equal counts on gen2, fall beyond the window on gen3
    gen_up = {8'd3, 8'd2, 8'd0, 8'd1};
    gen_dn = {8'd40, 8'd2, 8'd6, 8'd4};
    size_cmd_wr = 8'd6; size_dat_wr = 8'd0; size_rd = 8'd8;
    map_wr_cs = 2'd1; map_wr_stb = 2'd0; map_rd_cs = 2'd1; map_rd_stb = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready === 1'b1, "R1 reset ready", int'(ready), 1);
    chk(cs_n === 1'b1 && wr_n === 1'b1 && rd_n === 1'b1, "R1 reset strobes",
        int'({cs_n, wr_n, rd_n}), 7);
    chk(rs === 1'b1 && bus_oe === 1'b0, "R1 reset rs/oe", int'({rs, bus_oe}), 2);
    chk(done === 1'b0 && rd_valid === 1'b0, "R1 reset pulses", int'({done, rd_valid}), 0);
    rst_n = 1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      compare();
      req_valid = 1; req_read = 1'(c % 3 == 0); req_cmd = 1'(c % 2);
      req_wdata = DW'(c * 97); bus_in = DW'(c * 13 + 5);
      if (c == 200) mode_6800 = 1;
      if (c == 300) map_rd_stb = 2'd3;
    end
    mode_6800 = 0;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      compare();
      drive();
    end
    chk(n_rv > 0, "R9 coverage reads captured", n_rv, 1);
    chk(n_done > 0, "R2 coverage windows ended", n_done, 1);
    chk(n_acc6800 > 0, "R6 coverage 6800 accesses", n_acc6800, 1);
    chk(n_reads > n_rv, "R9 coverage uncaptured reads", n_reads, n_rv + 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule